// File: doc/BRIEF.md
# Serial Test Access Port with Identification and Bypass Paths

This block is the serial test port of a memory device. A sixteen-state controller steps through its states on each rising test-clock edge, under the control of the mode-select input. A three-bit instruction register and two data paths hang off that controller. The first data path is a 32-bit identification register and the second is a one-bit bypass stage. The active instruction and the controller state together decide which of the three serial paths lies between the serial input and the serial output.

There is no dedicated reset pin for the port. The port starts in its reset state when the asynchronous active-low power-on input is low. During operation it returns to that state when the mode-select input is held high for five rising edges. The serial output changes only on falling edges. It comes with an output-enable flag that is high only while a shift state is active. The pads are expected to pull the mode-select and serial-data inputs up, so that an unused port reads as all ones and stays in reset.

Top module: `tap_port`

## Requirements
- R1: The controller, the instruction path and both data paths sample `tms` and `tdi` on the rising edge of `tck`. State transitions follow the standard sixteen-state test-access sequence.
- R2: Holding `tms` high for five consecutive rising edges of `tck` brings the controller to its reset state from any state.
- R3: While `por_n` is low, the controller is held in its reset state and the active instruction is IDCODE. In the same condition `tdo_en` and `tdo` are 0, and this takes effect without waiting for a clock edge.
- R4: Every cycle spent in the reset state forces the active instruction back to IDCODE (code 001).
- R5: The instruction shift stage is 3 bits long and shifts least significant bit first, from `tdi` towards `tdo`. Capture-IR loads it with 001, so the first two bits out are 1 then 0.
- R6: Update-IR makes the shifted code the active instruction. Code 001 selects the identification register, and every other code (111 included) selects the bypass stage.
- R7: With IDCODE active, Capture-DR loads the 32-bit identification value with bit 0 forced to 1, whatever the parameter holds there. The register then shifts out least significant bit first, and `tdi` data appears at `tdo` after 32 shifts.
- R8: With a bypass instruction active, Capture-DR loads 0 into the one-bit bypass stage, and `tdi` data appears at `tdo` after one shift.
- R9: `tdo` and `tdo_en` change only on falling edges of `tck`. `tdo_en` is 1 exactly when the controller is in Shift-IR or Shift-DR, and `tdo` reads 0 whenever `tdo_en` is 0.
- R10: Passing through Pause-DR and Exit2-DR keeps the contents of the data register, and shifting then resumes with the next bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; inputs sampled on rising edge, output updated on falling edge |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data into the selected path |
| tdo | output | 1 | Serial data out of the selected path, 0 when not enabled |
| tdo_en | output | 1 | High while a shift state is active |

## Verification
The bench reads the identification register for 40 bits. A path of the wrong length would move where the `tdi` data reappears, and a missing forced bit 0 would show at the first bit out. It loads 111, then an unlisted code shifted in through a 6-bit scan, and checks the one-stage delay. A design that matched only 111, or kept stale shift-stage bits, would return identification data instead. The bench also cuts a scan with a Pause-DR detour, which exposes any shift during pause or exit. It escapes with five high `tms` bits from the middle of a bypass scan and pulses power-on reset asynchronously mid-shift; a controller or instruction latch that missed either reset would keep selecting the bypass stage. Throughout, `tdo` is compared just before and just after each rising edge, to catch output that moves on the wrong edge.

// File: rtl/tap_pkg.sv
// Shared definitions for the serial test port: instruction width and codes,
// the capture pattern of the instruction stage and the controller state type.
package tap_pkg;

    localparam int IR_W = 3;

    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_IDCODE  = 3'b001;
    localparam instr_t OP_BYPASS  = 3'b111;
    localparam instr_t IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SEL,
        ST_DR_CAP,
        ST_DR_SHIFT,
        ST_DR_EX1,
        ST_DR_PAUSE,
        ST_DR_EX2,
        ST_DR_UPD,
        ST_IR_SEL,
        ST_IR_CAP,
        ST_IR_SHIFT,
        ST_IR_EX1,
        ST_IR_PAUSE,
        ST_IR_EX2,
        ST_IR_UPD
    } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test-access controller.
// Assumes: tms already resolved to 0/1 at the pad; por_n asynchronous, active low.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_nx;

    // Next-state decode from the current state and tms.
    always_comb begin
        unique case (state)
            ST_RESET:    state_nx = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_nx = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_nx = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_nx = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_SHIFT: state_nx = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_EX1:   state_nx = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_nx = tms ? ST_DR_EX2   : ST_DR_PAUSE;
            ST_DR_EX2:   state_nx = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_nx = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_nx = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_nx = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_SHIFT: state_nx = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_EX1:   state_nx = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_nx = tms ? ST_IR_EX2   : ST_IR_PAUSE;
            ST_IR_EX2:   state_nx = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_nx = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    // State register, forced to reset by power-on.
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state <= ST_RESET;
        else        state <= state_nx;
    end

    // Count of consecutive high tms samples, saturating at five (checking only).
    logic [2:0] hi_run;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)            hi_run <= 3'd0;
        else if (!tms)         hi_run <= 3'd0;
        else if (hi_run < 3'd5) hi_run <= hi_run + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!por_n)
        (hi_run == 3'd5) |-> (state == ST_RESET)); // R2

    AST_RESET_EXIT: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET && !tms) |=> (state == ST_IDLE)); // R1

    AST_SHIFT_FROM_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_DR_CAP && !tms) |=> (state == ST_DR_SHIFT)); // R1

endmodule

// File: rtl/tap_ir.sv
// Instruction path: a shift stage loaded in Capture-IR and shifted in
// Shift-IR, and the active-instruction latch written in Update-IR.
// Assumes: state comes from tap_fsm on the same tck edge.
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state,
    output instr_t     instr,
    output logic       ir_so
);

    instr_t ir_sr;

    // Shift stage: capture the fixed pattern or shift toward bit 0.
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_sr <= IR_CAPTURE;
        end else begin
            case (state)
                ST_IR_CAP:   ir_sr <= IR_CAPTURE;
                ST_IR_SHIFT: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                default:     ;
            endcase
        end
    end

    // Active instruction: IDCODE on reset, shift stage on update.
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)                  instr <= OP_IDCODE;
        else if (state == ST_RESET)  instr <= OP_IDCODE;
        else if (state == ST_IR_UPD) instr <= ir_sr;
    end

    assign ir_so = ir_sr[0];

    AST_IR_RESET_IDCODE: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET) |=> (instr == OP_IDCODE)); // R4

    AST_IR_HOLD: assert property (@(posedge tck) disable iff (!por_n)
        (state != ST_IR_UPD && state != ST_RESET) |=> $stable(instr)); // R6

    AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_IR_CAP) |=> (ir_sr == IR_CAPTURE)); // R5

endmodule

// File: rtl/tap_dr.sv
// Data paths: the identification register and the one-bit bypass stage.
// Only the path chosen by sel_id captures and shifts; the other holds.
// Assumes: sel_id is stable outside Update-IR and reset.
module tap_dr
    import tap_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state,
    input  logic       sel_id,
    output logic       dr_so
);

    localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

    logic [ID_W-1:0] id_sr;
    logic            byp;

    // Identification register: capture fixed value, shift toward bit 0.
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            id_sr <= ID_CAP;
        end else if (sel_id) begin
            case (state)
                ST_DR_CAP:   id_sr <= ID_CAP;
                ST_DR_SHIFT: id_sr <= {tdi, id_sr[ID_W-1:1]};
                default:     ;
            endcase
        end
    end

    // Bypass stage: capture zero, shift one bit.
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            byp <= 1'b0;
        end else if (!sel_id) begin
            case (state)
                ST_DR_CAP:   byp <= 1'b0;
                ST_DR_SHIFT: byp <= tdi;
                default:     ;
            endcase
        end
    end

    assign dr_so = sel_id ? id_sr[0] : byp;

    AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_DR_CAP && !sel_id) |=> (byp == 1'b0)); // R8

    AST_ID_BIT0: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_DR_CAP && sel_id) |=> (id_sr[0] == 1'b1)); // R7

    AST_DR_PAUSE_HOLD: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_DR_PAUSE || state == ST_DR_EX2) |=> ($stable(id_sr) && $stable(byp))); // R10

endmodule

// File: rtl/tap_port.sv
// Top of the serial test port: controller, instruction path, data paths and
// the falling-edge output stage with its enable.
// Assumes: tms/tdi pulled up at the pad; por_n asynchronous, active low.
module tap_port
    import tap_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
    input  logic tck,
    input  logic por_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en
);

    tap_state_e state;
    instr_t     instr;
    logic       ir_so;
    logic       dr_so;
    logic       sel_id;
    logic       path_so;
    logic       in_shift;
    logic       tdo_q;
    logic       en_q;

    tap_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck   (tck),
        .por_n (por_n),
        .tdi   (tdi),
        .state (state),
        .instr (instr),
        .ir_so (ir_so)
    );

    assign sel_id = (instr == OP_IDCODE);

    tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck    (tck),
        .por_n  (por_n),
        .tdi    (tdi),
        .state  (state),
        .sel_id (sel_id),
        .dr_so  (dr_so)
    );

    assign in_shift = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
    assign path_so  = (state == ST_IR_SHIFT) ? ir_so : dr_so;

    // Output stage retimed to the falling edge of tck.
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            tdo_q <= path_so;
            en_q  <= in_shift;
        end
    end

    assign tdo    = en_q & tdo_q;
    assign tdo_en = en_q;

    AST_EN_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT)); // R9

    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!por_n)
        !tdo_en |-> (tdo == 1'b0)); // R9

endmodule

// File: tb/tap_port_bench.sv
// Scoreboard bench: step() drives tms/tdi and queues the expected output;
// a falling-edge monitor pops and compares.
module tap_port_bench;

    localparam logic [31:0] ID_PARAM = 32'h3C5A_96E0;
    localparam logic [31:0] ID_EXP   = 32'h3C5A_96E1;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b1;
    logic tdo;
    logic tdo_en;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit finished = 1'b0;
    logic last_tdo = 1'b0;
    logic last_en = 1'b0;

    logic [1:0] qv[$];
    string      qr[$];

    always #5 tck = ~tck;

    tap_port #(.ID_W(32), .ID_VALUE(ID_PARAM)) u_tap_port (
        .tck    (tck),
        .por_n  (por_n),
        .tms    (tms),
        .tdi    (tdi),
        .tdo    (tdo),
        .tdo_en (tdo_en)
    );

    task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual en/tdo=%b expected=%b", req, $time, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic d, input logic e_en, input logic e_tdo, input string req);
        @(negedge tck);
        #2;
        tms = t;
        tdi = d;
        qv.push_back({e_en, e_tdo});
        qr.push_back(req);
    endtask

    // Monitor: compare the popped expectation just after each falling edge.
    always @(negedge tck) begin
        #1;
        last_tdo = tdo;
        last_en  = tdo_en;
        if (qv.size() > 0) begin
            logic [1:0] v;
            string r;
            v = qv.pop_front();
            r = qr.pop_front();
            check({tdo_en, tdo} == v, r, {tdo_en, tdo}, v);
        end
    end

    // Output must not move at a rising edge (R9).
    always @(posedge tck) begin
        #1;
        if (started && por_n)
            check({tdo_en, tdo} == {last_en, last_tdo}, "R9 rising-edge stability",
                  {tdo_en, tdo}, {last_en, last_tdo});
    end

    task automatic five_ones(input string req);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 1'b0, req);
    endtask

    // DR scan from Run-Test/Idle; pa>0 inserts a Pause-DR detour before bit pa.
    task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] ex,
                           input int pa, input string req);
        step(1'b1, 1'b1, 1'b0, 1'b0, req);
        step(1'b0, 1'b1, 1'b0, 1'b0, req);
        step(1'b0, 1'b1, 1'b1, ex[0], req);
        for (int k = 1; k < n; k++) begin
            if (k == pa) begin
                step(1'b1, din[k-1], 1'b0, 1'b0, "R10 exit");
                step(1'b0, 1'b1, 1'b0, 1'b0, "R10 pause");
                step(1'b0, 1'b1, 1'b0, 1'b0, "R10 pause");
                step(1'b1, 1'b1, 1'b0, 1'b0, "R10 exit2");
                step(1'b0, 1'b1, 1'b1, ex[k], "R10 resume");
            end else begin
                step(1'b0, din[k-1], 1'b1, ex[k], req);
            end
        end
        step(1'b1, din[n-1], 1'b0, 1'b0, req);
        step(1'b1, 1'b1, 1'b0, 1'b0, req);
        step(1'b0, 1'b1, 1'b0, 1'b0, req);
    endtask

    // IR scan of n bits from Run-Test/Idle; loaded code is din[n-1:n-3].
    task automatic scan_ir(input int n, input logic [63:0] din, input string req);
        logic [63:0] ex;
        ex = '0;
        for (int k = 0; k < n; k++) ex[k] = (k < 3) ? 1'(3'b001 >> k) : din[k-3];
        step(1'b1, 1'b1, 1'b0, 1'b0, req);
        step(1'b1, 1'b1, 1'b0, 1'b0, req);
        step(1'b0, 1'b1, 1'b0, 1'b0, req);
        step(1'b0, 1'b1, 1'b1, ex[0], req);
        for (int k = 1; k < n; k++) step(1'b0, din[k-1], 1'b1, ex[k], req);
        step(1'b1, din[n-1], 1'b0, 1'b0, req);
        step(1'b1, 1'b1, 1'b0, 1'b0, req);
        step(1'b0, 1'b1, 1'b0, 1'b0, req);
    endtask

    function automatic logic [63:0] id_expect(input logic [63:0] din);
        logic [63:0] e;
        for (int k = 0; k < 64; k++) e[k] = (k < 32) ? ID_EXP[k] : din[k-32];
        return e;
    endfunction

    function automatic logic [63:0] byp_expect(input logic [63:0] din);
        logic [63:0] e;
        e[0] = 1'b0;
        for (int k = 1; k < 64; k++) e[k] = din[k-1];
        return e;
    endfunction

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge tck);
        #1;
        check({tdo_en, tdo} == 2'b00, "R3 held in power-on reset", {tdo_en, tdo}, 2'b00);
        #1;
        por_n = 1'b1;
        started = 1'b1;

        // R4 R7: identification after reset, 40 bits show the 32-bit length.
        five_ones("R2 reset");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R1 idle");
        d = 64'h0000_0000_0000_00A6;
        scan_dr(40, d, id_expect(d), 0, "R7 identification");

        // R5 R6 R8: load 111, bypass delay of one.
        scan_ir(3, 64'h7, "R5 capture 001");
        d = 64'h0000_0000_0000_00B4;
        scan_dr(8, d, byp_expect(d), 0, "R8 bypass 111");

        // R5 R6: 6-bit IR scan, last three bits 010 become active.
        scan_ir(6, 64'b010_110, "R5 ir delay");
        d = 64'h0000_0000_0000_0069;
        scan_dr(8, d, byp_expect(d), 0, "R6 other code bypass");

        // R6 R10: back to 001, identification scan with a pause detour.
        scan_ir(3, 64'h1, "R6 load idcode");
        d = 64'h0000_0000_0000_005D;
        scan_dr(40, d, id_expect(d), 10, "R10 pause scan");

        // R2 R4: escape from mid Shift-DR in bypass with five ones.
        scan_ir(3, 64'h7, "R6 load bypass");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R2 sel");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R2 cap");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R8 shift entry");
        five_ones("R2 five ones");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R4 idle");
        d = 64'h0000_0000_0000_0033;
        scan_dr(40, d, id_expect(d), 0, "R4 idcode after tms reset");

        // R3: asynchronous power-on pulse during a bypass shift.
        scan_ir(3, 64'h7, "R6 load bypass");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R3 sel");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R3 cap");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R3 shift entry");
        @(negedge tck);
        #2;
        started = 1'b0;
        tms = 1'b0;
        por_n = 1'b0;
        #1;
        check({tdo_en, tdo} == 2'b00, "R3 asynchronous clear", {tdo_en, tdo}, 2'b00);
        @(negedge tck);
        #2;
        por_n = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b0, "R3 idle");
        started = 1'b1;
        d = 64'h0000_0000_0000_00C5;
        scan_dr(40, d, id_expect(d), 0, "R3 idcode after power-on");

        repeat (3) @(negedge tck);
        #3;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule